// File: doc/BRIEF.md
# Watchdog and Power-On Reset Supervisor

This block drives the reset line of a host processor from two sources. A power-fail path watches an asynchronous supply-good flag that an external comparator produces. It holds reset while the supply is low, and it keeps reset asserted until the supply has stayed good without a break for a fixed hold time of 200 ms. The same hold applies after power-up.

A watchdog path watches a pin that also serves as a serial chip-select. Every falling edge on that pin restarts the watchdog count. If no falling edge arrives within the selected timeout, the block issues a 200 ms reset pulse. This happens whether the pin is stuck high or stuck low.

All timing comes from an internal prescaler. It divides the system clock by `CLKS_PER_MS` to produce a 1 ms tick, so every duration is a whole number of milliseconds and is accurate to within one tick. Both asynchronous inputs pass through two-flop synchronizers before they are used.

Top module: `reset_supervisor`

## Requirements
- R1: `rst_out_n` is active low. It is 0 while `rst_n` is low, and it stays 0 after `rst_n` releases until the supply has been good for the hold time.
- R2: Within 4 clock cycles of `supply_ok_async` going low, `rst_out_n` is 0.
- R3: `rst_out_n` returns to 1 only once `supply_ok_async` has been continuously high for between HOLD_MS-1 and HOLD_MS milliseconds, plus at most 5 cycles of pipeline delay.
- R4: A supply dip during a hold restarts the full hold, counted from the moment the supply returns.
- R5: A falling edge on `csw_pin` restarts the watchdog count from zero. Kicks spaced closer than the timeout never cause a reset.
- R6: With the watchdog enabled and no falling edge on `csw_pin`, a reset occurs after the timeout. This holds with the pin static high and with the pin static low.
- R7: `wd_sel` picks the timeout: 2'b00 = 1400 ms, 2'b01 = 600 ms, 2'b10 = 200 ms. 2'b11 disables the watchdog. `wd_en` = 0 also disables it.
- R8: A watchdog expiry gives a reset pulse of HOLD_MS milliseconds. After the pulse ends, the next expiry is a full timeout later.
- R9: The watchdog count is held at zero while reset is asserted. No expiry builds up during a long supply-low period or during a hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset of the block's logic |
| supply_ok_async | input | 1 | Asynchronous supply-good flag, 1 means the supply is above the trip level |
| csw_pin | input | 1 | Shared chip-select / watchdog kick pin, asynchronous |
| wd_en | input | 1 | Watchdog enable |
| wd_sel | input | 2 | Timeout select code |
| rst_out_n | output | 1 | Active-low reset to the host |

## Verification
A hold counter stuck short of its end value shows up as `rst_out_n` stuck at 0. A counter that clears late or skips the restart after a dip releases reset up to one hold period early, and the bench catches this at the first sample taken inside the hold window. A watchdog count that fails to clear on a kick, or that keeps counting during reset, fires a reset within one timeout of the last kick or of reset release. A wrong timeout decode moves the expiry outside its one-tick window, which shows at the next window sample.

// File: rtl/rsup_pkg.sv
// Shared types and helpers for the reset supervisor.
// Assumes timeouts are given in milliseconds as positive integers.
package rsup_pkg;

    typedef enum logic [1:0] {
        WD_T_LONG  = 2'b00,
        WD_T_MID   = 2'b01,
        WD_T_SHORT = 2'b10,
        WD_T_OFF   = 2'b11
    } wd_sel_e;

    // Width needed to hold the value n.
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/rsup_sync.sv
// Two-flop synchronizer for a vector of asynchronous inputs.
// Assumes each bit is independent; RST_VAL gives the reset level per bit.
module rsup_sync #(
    parameter int unsigned   WIDTH   = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] meta_q;

    // Two register stages per bit to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q_sync <= RST_VAL;
        end else begin
            meta_q <= d_async;
            q_sync <= meta_q;
        end
    end
endmodule

// File: rtl/rsup_prescaler.sv
// Divides the system clock to a one-cycle pulse every millisecond.
// Assumes CLKS_PER_MS >= 1.
module rsup_prescaler #(
    parameter int unsigned CLKS_PER_MS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    output logic ms_tick
);
    localparam int unsigned PW = rsup_pkg::cnt_width(CLKS_PER_MS - 1);
    localparam logic [PW-1:0] LAST = PW'(CLKS_PER_MS - 1);

    logic [PW-1:0] div_q;

    // Free-running divider that wraps at the last clock of each millisecond.
    always_ff @(posedge clk) begin
        if (!rst_n)            div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else                   div_q <= div_q + 1'b1;
    end

    assign ms_tick = (div_q == LAST);

    assert_tick_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ms_tick |=> (div_q == '0));
endmodule

// File: rtl/rsup_hold.sv
// Reset hold timer: clears on supply loss or a watchdog expiry and counts
// ms ticks up to HOLD_MS; reset is active until the count reaches HOLD_MS.
// Assumes supply_ok is already synchronized.
module rsup_hold #(
    parameter int unsigned HOLD_MS = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ms_tick,
    input  logic supply_ok,
    input  logic wd_fire,
    output logic hold_active
);
    localparam int unsigned HW = rsup_pkg::cnt_width(HOLD_MS);
    localparam logic [HW-1:0] HOLD_END = HW'(HOLD_MS);

    logic [HW-1:0] hold_q;

    // Restart on any reset cause, otherwise count ticks up to the end value.
    always_ff @(posedge clk) begin
        if (!rst_n)                         hold_q <= '0;
        else if (!supply_ok || wd_fire)     hold_q <= '0;
        else if (ms_tick && hold_q != HOLD_END) hold_q <= hold_q + 1'b1;
    end

    assign hold_active = (hold_q != HOLD_END);

    assert_supply_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> hold_active);
    assert_hold_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hold_q <= HOLD_END);
    assert_release_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_active) |-> $past(ms_tick) && $past(supply_ok));
    assert_fire_restarts_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wd_fire |=> (hold_q == '0));
endmodule

// File: rtl/rsup_watchdog.sv
// Watchdog counter: counts ms ticks since the last kick and fires once the
// selected timeout is reached. Held at zero while reset is active or disabled.
// Assumes kick is a one-cycle pulse from a synchronized falling edge.
module rsup_watchdog #(
    parameter int unsigned TO_LONG_MS  = 1400,
    parameter int unsigned TO_MID_MS   = 600,
    parameter int unsigned TO_SHORT_MS = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ms_tick,
    input  logic       kick,
    input  logic       hold_clr,
    input  logic       wd_en,
    input  logic [1:0] wd_sel,
    output logic       wd_fire
);
    import rsup_pkg::*;

    localparam int unsigned WW = cnt_width(TO_LONG_MS);

    logic [WW-1:0] wd_q;
    logic [WW:0]   limit;
    logic [WW:0]   next_val;
    logic          armed;

    // Decode the timeout select into a limit in milliseconds.
    always_comb begin
        unique case (wd_sel_e'(wd_sel))
            WD_T_LONG:  limit = (WW+1)'(TO_LONG_MS);
            WD_T_MID:   limit = (WW+1)'(TO_MID_MS);
            WD_T_SHORT: limit = (WW+1)'(TO_SHORT_MS);
            default:    limit = '0;
        endcase
    end

    assign armed    = wd_en && (wd_sel != WD_T_OFF) && !hold_clr;
    assign next_val = {1'b0, wd_q} + 1'b1;
    assign wd_fire  = armed && !kick && ms_tick && (next_val >= limit);

    // Clear on kick, reset or disable; otherwise count ticks and wrap on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)                 wd_q <= '0;
        else if (!armed || kick)    wd_q <= '0;
        else if (ms_tick) begin
            if (next_val >= limit)  wd_q <= '0;
            else                    wd_q <= next_val[WW-1:0];
        end
    end

    assert_kick_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (wd_q == '0));
    assert_disabled_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wd_en || wd_sel == WD_T_OFF) |=> (wd_q == '0) && !wd_fire);
    assert_clear_in_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hold_clr |=> (wd_q == '0));
endmodule

// File: rtl/reset_supervisor.sv
// Top of the reset supervisor: synchronizes the supply flag and the shared
// chip-select/watchdog pin, detects kicks on falling edges, and drives an
// active-low registered reset from the hold timer.
// Assumes clk runs continuously and CLKS_PER_MS clocks make one millisecond.
module reset_supervisor #(
    parameter int unsigned CLKS_PER_MS = 1000,
    parameter int unsigned HOLD_MS     = 200,
    parameter int unsigned TO_LONG_MS  = 1400,
    parameter int unsigned TO_MID_MS   = 600,
    parameter int unsigned TO_SHORT_MS = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       supply_ok_async,
    input  logic       csw_pin,
    input  logic       wd_en,
    input  logic [1:0] wd_sel,
    output logic       rst_out_n
);
    localparam int unsigned SYNC_W = 2;
    localparam int unsigned IDX_CSW = 1;
    localparam int unsigned IDX_SUP = 0;

    logic [SYNC_W-1:0] sync_q;
    logic csw_s, csw_prev_q, supply_s, kick, ms_tick, wd_fire, hold_active;

    rsup_sync #(.WIDTH(SYNC_W), .RST_VAL(2'b10)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({csw_pin, supply_ok_async}),
        .q_sync  (sync_q)
    );

    assign csw_s    = sync_q[IDX_CSW];
    assign supply_s = sync_q[IDX_SUP];

    // Delayed copy of the synchronized pin for falling-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) csw_prev_q <= 1'b1;
        else        csw_prev_q <= csw_s;
    end

    assign kick = csw_prev_q && !csw_s;

    rsup_prescaler #(.CLKS_PER_MS(CLKS_PER_MS)) i_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .ms_tick (ms_tick)
    );

    rsup_watchdog #(
        .TO_LONG_MS (TO_LONG_MS),
        .TO_MID_MS  (TO_MID_MS),
        .TO_SHORT_MS(TO_SHORT_MS)
    ) i_wd (
        .clk      (clk),
        .rst_n    (rst_n),
        .ms_tick  (ms_tick),
        .kick     (kick),
        .hold_clr (hold_active),
        .wd_en    (wd_en),
        .wd_sel   (wd_sel),
        .wd_fire  (wd_fire)
    );

    rsup_hold #(.HOLD_MS(HOLD_MS)) i_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .ms_tick     (ms_tick),
        .supply_ok   (supply_s),
        .wd_fire     (wd_fire),
        .hold_active (hold_active)
    );

    // Registered active-low output, asserted during the block's own reset.
    always_ff @(posedge clk) begin
        if (!rst_n) rst_out_n <= 1'b0;
        else        rst_out_n <= !hold_active;
    end

    assert_out_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        hold_active |=> !rst_out_n);
    assert_fire_resets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wd_fire |=> ##1 !rst_out_n);
endmodule

// File: tb/test_reset_supervisor.sv
module test_reset_supervisor;
    localparam int CLK_PERIOD = 10;
    localparam int CPM  = 2;
    localparam int HOLD = 200;

    logic clk = 0, rst_n = 0, supply = 1, csw = 1, wd_en = 1;
    logic [1:0] wd_sel = 2'b11;
    logic rst_out_n;
    int n_checks = 0, n_fail = 0;
    bit done = 0;

    reset_supervisor #(.CLKS_PER_MS(CPM), .HOLD_MS(HOLD)) i_reset_supervisor (
        .clk(clk), .rst_n(rst_n), .supply_ok_async(supply), .csw_pin(csw),
        .wd_en(wd_en), .wd_sel(wd_sel), .rst_out_n(rst_out_n));

    always #(CLK_PERIOD/2) clk = ~clk;

    // Timeout in ms per the selection table of R7; 0 means disabled.
    function automatic int to_ms(input logic [1:0] s);
        case (s)
            2'b00: return 1400;
            2'b01: return 600;
            2'b10: return 200;
            default: return 0;
        endcase
    endfunction
    // Last cycle count at which an event of d ms cannot yet have happened.
    function automatic int early(input int d); return (d - 1) * CPM - 2; endfunction
    // Cycle count by which an event of d ms must have happened.
    function automatic int late(input int d);  return d * CPM + 6; endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: rst_out_n=%0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask
    task automatic cyc(input int n); repeat (n) @(negedge clk); endtask
    task automatic expect_out(input logic v, input string req);
        chk(rst_out_n === v, req, int'(rst_out_n), int'(v));
    endtask
    task automatic kick_pin();
        csw = 0; cyc(3); csw = 1; cyc(1);
    endtask
    task automatic wait_rise(input int lim, input string req);
        int k = 0;
        while (rst_out_n !== 1'b1 && k < lim) begin cyc(1); k++; end
        chk(rst_out_n === 1'b1, req, int'(rst_out_n), 1);
    endtask
    task automatic wait_fall(input int lim, input string req);
        int k = 0;
        while (rst_out_n !== 1'b0 && k < lim) begin cyc(1); k++; end
        chk(rst_out_n === 1'b0, req, int'(rst_out_n), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        cyc(3);
        expect_out(1'b0, "R1 during rst_n");
        @(negedge clk) rst_n = 1;
        // R1/R3: power-up hold
        cyc(early(HOLD)); expect_out(1'b0, "R1 power-up hold");
        cyc(late(HOLD) - early(HOLD)); expect_out(1'b1, "R3 power-up release");

        // R2: supply loss asserts within 4 cycles
        supply = 0; cyc(4); expect_out(1'b0, "R2 supply low");
        cyc(50);
        supply = 1;
        cyc(early(HOLD)); expect_out(1'b0, "R3 still held");
        cyc(late(HOLD) - early(HOLD)); expect_out(1'b1, "R3 released");

        // R4: dip in the middle of a hold restarts it
        supply = 0; cyc(10); supply = 1;
        cyc(100 * CPM); supply = 0; cyc(6); supply = 1;
        cyc(early(HOLD)); expect_out(1'b0, "R4 hold restarted");
        cyc(late(HOLD) - early(HOLD)); expect_out(1'b1, "R4 release after restart");

        // R7: disabled by code 11 with a stuck pin
        wd_sel = 2'b11;
        for (int i = 0; i < 16; i++) begin cyc(200); expect_out(1'b1, "R7 sel=11 disabled"); end
        // R7: disabled by wd_en=0 with a short timeout selected
        wd_en = 0; wd_sel = 2'b10;
        for (int i = 0; i < 6; i++) begin cyc(200); expect_out(1'b1, "R7 wd_en=0 disabled"); end
        kick_pin(); wd_en = 1;

        // R6/R7: pin stuck high, 1400 ms
        wd_sel = 2'b00; kick_pin();
        cyc(early(to_ms(2'b00))); expect_out(1'b1, "R7 1400ms not yet");
        cyc(late(to_ms(2'b00)) - early(to_ms(2'b00))); expect_out(1'b0, "R6 pin high expiry");
        // R8: pulse length
        cyc(early(HOLD) - 8); expect_out(1'b0, "R8 pulse still active");
        wait_rise(5 * CPM + 20, "R8 pulse ends");
        // R8/R9: next expiry a full timeout after pulse end
        cyc(early(to_ms(2'b00))); expect_out(1'b1, "R8 no early re-expiry");
        wait_fall(2 * CPM + 12, "R8 re-expiry");
        wait_rise(late(HOLD), "R8 second pulse ends");

        // R6/R7: pin stuck low, 600 ms
        wd_sel = 2'b01; kick_pin(); csw = 0; cyc(8);
        cyc(early(to_ms(2'b01)) - 8); expect_out(1'b1, "R7 600ms not yet");
        cyc(late(to_ms(2'b01)) - early(to_ms(2'b01))); expect_out(1'b0, "R6 pin low expiry");
        csw = 1; wait_rise(late(HOLD), "R6 pulse ends");

        // R9: long supply loss with a short timeout, no stacked expiry
        wd_sel = 2'b10; supply = 0; cyc(500 * CPM); supply = 1;
        wait_rise(late(HOLD) + 10, "R9 release after hold");
        cyc(early(to_ms(2'b10))); expect_out(1'b1, "R9 count started at release");

        // R5: random kick gaps shorter than the timeout never reset
        for (int s = 0; s < 3; s++) begin
            kick_pin(); wd_sel = 2'(s); cyc(2);
            for (int i = 0; i < 10; i++) begin
                int gap = 1 + int'($urandom % (early(to_ms(2'(s))) - 12));
                kick_pin();
                cyc(gap);
                expect_out(1'b1, "R5 kicked in time");
            end
        end
        // R5: kick just inside the short timeout
        wd_sel = 2'b10; kick_pin();
        for (int i = 0; i < 3; i++) begin
            cyc(early(to_ms(2'b10)) - 8); kick_pin(); expect_out(1'b1, "R5 late kick");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule